// File: doc/BRIEF.md
# Bus Phase Change Sequencer

This block sits on the target side of a parallel peripheral bus. It drives the three information-phase lines (message, command/data and direction) and reports when the bus has settled after a phase change. A controller puts a four-bit phase code on `req_code` and pulses `req_valid`. The block then moves the bus to that phase and pulses `done` once the required settle time has passed.

Before it moves any line, the block waits for the initiator's acknowledge to go inactive. A pending bus reset skips this wait. All three lines switch on one clock edge. The settle time depends on two things: whether the direction line flipped, and whether the host is a legacy host. A legacy host also gets a long pause before a data phase. If the transfer engine is still busy when the change is applied, the block does not complete. It pulses `force_reset` instead. All delays are clock-cycle counts set by parameters.

Top module: `bus_phase_sequencer`

## Requirements
- R1: After reset the bus is released: `ctl_oe`=0, all three lines 0, and `busy`, `done` and `force_reset` are 0.
- R2: If the requested phase equals the current phase, `done` is 1 on the cycle after the request, and `busy` and the lines do not change. A release request while already released counts as the same phase.
- R3: A changing request waits while `ack_in`=1 and `bus_reset_pending`=0, with the lines held. The change is applied on the first edge on which `ack_in`=0 or `bus_reset_pending`=1.
- R4: Code bit 2 drives `msg_out`, bit 1 drives `cd_out`, bit 0 drives `io_out`, and bit 3=0 means driven. All three lines and `ctl_oe`=1 take their new values on the same edge.
- R5: A code with bit 3=1 releases the bus: `ctl_oe` and all lines go to 0 on the apply edge, and `done` is high on the following cycle with no settle time.
- R6: After a driven change, `done` rises SETTLE_CYC cycles after the lines change. Add IO_TURN_CYC if the direction bit differs from before (a released bus counts as direction 1). Add LEGACY_SETTLE_CYC if `legacy_mode`=1.
- R7: In legacy mode, a driven request with bits 2 and 1 both 0 (a data phase) waits an extra LEGACY_DATA_CYC cycles between the acknowledge condition and the line change.
- R8: If `xfer_idle`=0 on the apply edge, `force_reset` pulses for one cycle. The lines and `ctl_oe` stay unchanged, `done` is not raised, and the block returns to idle.
- R9: Requests made while `busy`=1 are ignored. `done` and `force_reset` are only ever high while `busy`=0, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Phase request strobe |
| req_code | input | 4 | {release, msg, cd, io} phase code |
| ack_in | input | 1 | Initiator acknowledge, active high |
| legacy_mode | input | 1 | Legacy host compatibility |
| xfer_idle | input | 1 | Transfer engine idle indication |
| bus_reset_pending | input | 1 | Bus reset pending; bypasses the acknowledge wait |
| msg_out | output | 1 | Message line |
| cd_out | output | 1 | Command/data line |
| io_out | output | 1 | Direction line |
| ctl_oe | output | 1 | Control output enable |
| busy | output | 1 | A phase change is in progress |
| done | output | 1 | One-cycle completion pulse |
| force_reset | output | 1 | One-cycle pulse: change aborted, a reset is needed |

## Verification
The assertions check on every cycle that the lines hold while acknowledge blocks a change, that an aborted change leaves the lines untouched, that `done` and `force_reset` are exclusive and occur only when idle, and that a same-phase request completes on the next cycle. The exact settle lengths, the legacy pre-data pause, the release path and the dropping of requests made while busy can only be shown by the bench's scenarios. There, a behavioural model predicts every output on every clock, and measured latencies are compared against the R6 and R7 sums.

// File: rtl/bus_phase_sequencer.sv
module bus_phase_sequencer #(
  parameter int SETTLE_CYC        = 20,
  parameter int IO_TURN_CYC       = 20,
  parameter int LEGACY_SETTLE_CYC = 5000,
  parameter int LEGACY_DATA_CYC   = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [3:0] req_code,
  input  logic       ack_in,
  input  logic       legacy_mode,
  input  logic       xfer_idle,
  input  logic       bus_reset_pending,
  output logic       msg_out,
  output logic       cd_out,
  output logic       io_out,
  output logic       ctl_oe,
  output logic       busy,
  output logic       done,
  output logic       force_reset
);
  localparam int SUM_MAX = SETTLE_CYC + IO_TURN_CYC + LEGACY_SETTLE_CYC;
  localparam int CNT_MAX = (SUM_MAX > LEGACY_DATA_CYC) ? SUM_MAX : LEGACY_DATA_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_ACK, S_PRE, S_SETTLE} st_t;
  st_t st;

  logic          rel_q;
  logic [2:0]    lines_q;
  logic [3:0]    pend_q;
  logic [CW-1:0] cnt_q;

  wire same      = req_code[3] ? rel_q : (!rel_q && req_code[2:0] == lines_q);
  wire pend_data = !pend_q[3] && pend_q[2:1] == 2'b00;
  wire ack_clear = !ack_in || bus_reset_pending;
  wire go_pre    = (st == S_ACK) && ack_clear && legacy_mode && pend_data;
  wire go_apply  = ((st == S_ACK) && ack_clear && !(legacy_mode && pend_data)) ||
                   ((st == S_PRE) && cnt_q == CW'(1));
  wire old_io    = rel_q | lines_q[0];
  wire [CW-1:0] settle_len = CW'(SETTLE_CYC)
                           + ((old_io != pend_q[0]) ? CW'(IO_TURN_CYC) : '0)
                           + (legacy_mode ? CW'(LEGACY_SETTLE_CYC) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      rel_q       <= 1'b1;
      lines_q     <= '0;
      pend_q      <= 4'b1000;
      cnt_q       <= '0;
      done        <= 1'b0;
      force_reset <= 1'b0;
    end else begin
      done        <= 1'b0;
      force_reset <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid) begin
            if (same) done <= 1'b1;
            else begin
              pend_q <= req_code;
              st     <= S_ACK;
            end
          end
        S_ACK:
          if (go_pre) begin
            cnt_q <= CW'(LEGACY_DATA_CYC);
            st    <= S_PRE;
          end
        S_PRE:
          if (cnt_q != CW'(1)) cnt_q <= cnt_q - CW'(1);
        S_SETTLE:
          if (cnt_q == CW'(1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else cnt_q <= cnt_q - CW'(1);
        default: st <= S_IDLE;
      endcase
      if (go_apply) begin
        if (!xfer_idle) begin
          force_reset <= 1'b1;
          st          <= S_IDLE;
        end else if (pend_q[3]) begin
          rel_q   <= 1'b1;
          lines_q <= '0;
          done    <= 1'b1;
          st      <= S_IDLE;
        end else begin
          rel_q   <= 1'b0;
          lines_q <= pend_q[2:0];
          cnt_q   <= settle_len;
          st      <= S_SETTLE;
        end
      end
    end
  end

  assign {msg_out, cd_out, io_out} = lines_q;
  assign ctl_oe = !rel_q;
  assign busy   = (st != S_IDLE);

  p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && ack_in && !bus_reset_pending) |=> $stable({msg_out, cd_out, io_out, ctl_oe}));

  p_abort_keeps_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_reset) |-> $stable({msg_out, cd_out, io_out, ctl_oe}));

  p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && force_reset));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || force_reset) |-> !busy);

  p_same_quick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && same) |=> (done && !busy && $stable({msg_out, cd_out, io_out, ctl_oe})));
endmodule

// File: tb/bus_phase_sequencer_test.sv
`timescale 1ns/1ps
module bus_phase_sequencer_test;
  localparam int S  = 4;
  localparam int T  = 3;
  localparam int L  = 10;
  localparam int LD = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [3:0] req_code = 4'b1000;
  logic ack_in = 0, legacy_mode = 0, xfer_idle = 1, bus_reset_pending = 0;
  logic msg_out, cd_out, io_out, ctl_oe, busy, done, force_reset;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bus_phase_sequencer #(.SETTLE_CYC(S), .IO_TURN_CYC(T),
                        .LEGACY_SETTLE_CYC(L), .LEGACY_DATA_CYC(LD)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .ack_in(ack_in), .legacy_mode(legacy_mode), .xfer_idle(xfer_idle),
    .bus_reset_pending(bus_reset_pending), .msg_out(msg_out), .cd_out(cd_out),
    .io_out(io_out), .ctl_oe(ctl_oe), .busy(busy), .done(done),
    .force_reset(force_reset));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: mode 0 idle, 1 waiting ack, 2 legacy pause, 3 settling
  int m_mode = 0, m_left = 0;
  bit m_rel = 1;
  bit [2:0] m_lines = 0;
  bit [3:0] m_pend = 4'b1000;
  bit m_done = 0, m_frc = 0;

  task automatic m_apply();
    if (!xfer_idle) begin
      m_frc = 1; m_mode = 0;
    end else if (m_pend[3]) begin
      m_rel = 1; m_lines = 0; m_done = 1; m_mode = 0;
    end else begin
      bit oldio;
      oldio = m_rel ? 1'b1 : m_lines[0];
      m_left = S + ((oldio != m_pend[0]) ? T : 0) + (legacy_mode ? L : 0);
      m_rel = 0; m_lines = m_pend[2:0]; m_mode = 3;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_rel = 1; m_lines = 0; m_done = 0; m_frc = 0;
    end else begin
      m_done = 0; m_frc = 0;
      if (m_mode == 0) begin
        if (req_valid) begin
          if (req_code[3] ? m_rel : (!m_rel && req_code[2:0] == m_lines)) m_done = 1;
          else begin m_pend = req_code; m_mode = 1; end
        end
      end else if (m_mode == 1) begin
        if (!ack_in || bus_reset_pending) begin
          if (legacy_mode && !m_pend[3] && m_pend[2:1] == 0) begin m_mode = 2; m_left = LD; end
          else m_apply();
        end
      end else if (m_mode == 2) begin
        if (m_left == 1) m_apply(); else m_left--;
      end else begin
        if (m_left == 1) begin m_mode = 0; m_done = 1; end else m_left--;
      end
    end
    #5;
    if (rst_n) begin
      chk({msg_out, cd_out, io_out} == m_lines, "R4 lines", {msg_out, cd_out, io_out}, m_lines);
      chk(ctl_oe == !m_rel, "R5 ctl_oe", ctl_oe, !m_rel);
      chk(busy == (m_mode != 0), "R9 busy", busy, m_mode != 0);
      chk(done == m_done, "R6 done", done, m_done);
      chk(force_reset == m_frc, "R8 force_reset", force_reset, m_frc);
    end
  end

  task automatic run_req(input logic [3:0] code, output int n);
    @(negedge clk);
    req_valid = 1; req_code = code;
    n = 0;
    do begin
      @(posedge clk); #6;
      n++;
      req_valid = 0;
    end while (!done && !force_reset && n < 500);
  endtask

  int n;

  initial begin
    #(20 * 20000);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk({ctl_oe, msg_out, cd_out, io_out, busy, done, force_reset} == 0, "R1 reset",
        {ctl_oe, msg_out, cd_out, io_out, busy, done, force_reset}, 0);
    rst_n = 1;
    @(negedge clk);

    // data-out from released: direction 1 -> 0
    run_req(4'b0000, n);
    chk(n == S + T + 2, "R6 settle with turn", n, S + T + 2);
    chk(ctl_oe && {msg_out, cd_out, io_out} == 3'b000, "R4 data-out", {msg_out, cd_out, io_out}, 0);

    run_req(4'b0000, n);
    chk(n == 1, "R2 same phase", n, 1);

    // command phase 010, same direction
    run_req(4'b0010, n);
    chk(n == S + 2, "R6 settle no turn", n, S + 2);

    // acknowledge held
    @(negedge clk); ack_in = 1; req_valid = 1; req_code = 4'b0111;
    @(negedge clk); req_valid = 0;
    repeat (5) @(negedge clk);
    chk({msg_out, cd_out, io_out} == 3'b010, "R3 hold during ack", {msg_out, cd_out, io_out}, 3'b010);
    ack_in = 0;
    @(negedge clk);
    chk({msg_out, cd_out, io_out} == 3'b111, "R3 apply after ack", {msg_out, cd_out, io_out}, 3'b111);
    while (!done) @(negedge clk);

    // reset pending bypasses ack
    ack_in = 1; bus_reset_pending = 1;
    run_req(4'b0110, n);
    chk(n == S + T + 2, "R3 reset bypass", n, S + T + 2);
    ack_in = 0; bus_reset_pending = 0;

    // request while busy dropped
    @(negedge clk); req_valid = 1; req_code = 4'b0001;
    @(negedge clk); req_valid = 1; req_code = 4'b0011;
    @(negedge clk); req_valid = 0;
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    chk({msg_out, cd_out, io_out} == 3'b001 && !busy, "R9 ignored while busy",
        {msg_out, cd_out, io_out}, 3'b001);

    // legacy data-out: pause plus legacy settle, direction flips
    legacy_mode = 1;
    run_req(4'b0000, n);
    chk(n == LD + S + T + L + 2, "R7 legacy data", n, LD + S + T + L + 2);
    run_req(4'b0011, n);
    chk(n == S + T + L + 2, "R6 legacy non-data", n, S + T + L + 2);
    legacy_mode = 0;

    // engine busy at apply
    xfer_idle = 0;
    run_req(4'b0100, n);
    chk(n == 2 && force_reset, "R8 abort", n, 2);
    @(negedge clk);
    chk({msg_out, cd_out, io_out} == 3'b011 && !done, "R8 lines kept", {msg_out, cd_out, io_out}, 3'b011);
    xfer_idle = 1;

    run_req(4'b1000, n);
    chk(n == 2 && !ctl_oe, "R5 release", n, 2);
    run_req(4'b1101, n);
    chk(n == 1, "R2 release when released", n, 1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule